// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block produces the word-address stream for a synchronous burst read from a word-addressed memory array. The caller presents a start address together with three read-configuration controls: a 3-bit burst-length code, a wrap-disable bit and an edge-select bit. The sequencer then emits one word address per active clock edge until the burst ends.

Fixed bursts are 4, 8 or 16 words long. Each one either increments linearly across its length boundary or wraps inside the aligned block of its own length. A continuous burst always increments linearly and runs to the top of the address space. A `last_o` flag marks the final beat. A `stop_i` pulse ends a burst early.

Wait-state insertion, latency counting and the array itself sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` and `last_o` are 0 until a burst is started.
- R2: When `valid_o` is 0 and `start_i` is 1 at an active edge, that edge latches the configuration and makes `valid_o` 1 with `addr_o` equal to `start_addr_i`.
- R3: With `wrap_dis_i` = 1 and a fixed length, each following beat address is the previous one plus 1, modulo 2^ADDR_W, even across the length boundary (a 4-word burst from word 2 gives 2,3,4,5).
- R4: With `wrap_dis_i` = 0 and a fixed length L, beat i has address `(start & ~(L-1)) | ((start + i) & (L-1))`.
- R5: The length code `blen_i` is decoded as 001 = 4 words, 010 = 8 words, 011 = 16 words and 111 = continuous. Codes 000, 100, 101 and 110 act as 4 words.
- R6: A continuous burst ignores `wrap_dis_i`. It gives start, start+1, and so on, and its final beat is at the all-ones address, where `last_o` is 1.
- R7: `last_o` is 1 only on the final beat of a burst: beat L-1 of a fixed burst, or the all-ones address of a continuous burst. The next active edge clears `valid_o`.
- R8: While `valid_o` is 1, the sequencer ignores `start_i`, `start_addr_i`, `blen_i` and `wrap_dis_i`, and the address sequence continues unchanged.
- R9: When `stop_i` is 1 during a beat, the next active edge clears `valid_o`.
- R10: With `edge_fall_i` = 0 the sequencer advances on the rising edge of `clk_i`; with `edge_fall_i` = 1 it advances on the falling edge, and rising edges change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| edge_fall_i | input | 1 | 1: falling edge is active; 0: rising edge is active |
| start_i | input | 1 | Request a new burst (taken only when idle) |
| start_addr_i | input | ADDR_W | First word address of the burst |
| blen_i | input | 3 | Burst-length code |
| wrap_dis_i | input | 1 | 1: linear fixed bursts; 0: wrapping fixed bursts |
| stop_i | input | 1 | End the current burst after this beat |
| addr_o | output | ADDR_W | Current beat word address |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
A start request sampled at an active edge shows its first address on `addr_o` right after that same edge. Each later beat appears one active edge after the one before it. After a final beat or a stop request, `valid_o` falls one active edge later. The bench drives and samples 1 ns after each active edge, so every check sees exactly the beat that edge produced, and after the final beat it checks once more for the idle state. To confirm that a rising edge leaves the outputs alone in falling-edge mode, the bench samples right after such an edge and then again after the following falling edge.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  typedef enum logic [1:0] {BL_4, BL_8, BL_16, BL_CONT} blen_e;
  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/burst_clk_sel.sv
`timescale 1ns/1ps
module burst_clk_sel (
  input  logic clk_i,
  input  logic fall_i,
  output logic clk_o
);
  // static select: inverting the clock turns falling edges into rising ones
  assign clk_o = clk_i ^ fall_i;
endmodule

// File: rtl/burst_len_dec.sv
`timescale 1ns/1ps
module burst_len_dec
  import burst_seq_pkg::*;
(
  input  logic [2:0]       code_i,
  output blen_e            len_o,
  output logic [CNT_W-1:0] mask_o,
  output logic             cont_o
);
  always_comb begin
    unique case (code_i)
      3'b010:  len_o = BL_8;
      3'b011:  len_o = BL_16;
      3'b111:  len_o = BL_CONT;
      default: len_o = BL_4;
    endcase
  end

  always_comb begin
    unique case (len_o)
      BL_8:    mask_o = CNT_W'(7);
      BL_16:   mask_o = CNT_W'(15);
      BL_CONT: mask_o = '1;
      default: mask_o = CNT_W'(3);
    endcase
  end

  assign cont_o = (len_o == BL_CONT);
endmodule

// File: rtl/burst_next_addr.sv
`timescale 1ns/1ps
module burst_next_addr
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  mask_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] wide_mask;
  logic [ADDR_W-1:0] inc;

  assign wide_mask = ADDR_W'(mask_i);
  assign inc       = addr_i + ADDR_W'(1);
  assign next_o    = wrap_i ? ((addr_i & ~wide_mask) | (inc & wide_mask)) : inc;
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_fall_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        blen_i,
  input  logic              wrap_dis_i,
  input  logic              stop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              last_o
);
  logic              act_clk;
  blen_e             len_d;
  logic [CNT_W-1:0]  mask_d;
  logic              cont_d;
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_q;
  logic              cont_q;

  burst_clk_sel u_clk_sel (
    .clk_i (clk_i),
    .fall_i(edge_fall_i),
    .clk_o (act_clk)
  );

  burst_len_dec u_len_dec (
    .code_i(blen_i),
    .len_o (len_d),
    .mask_o(mask_d),
    .cont_o(cont_d)
  );

  burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .addr_i(addr_q),
    .mask_i(mask_q),
    .wrap_i(wrap_q),
    .next_o(addr_nxt)
  );

  always_ff @(posedge act_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        addr_q <= start_addr_i;
        mask_q <= mask_d;
        cont_q <= cont_d;
        wrap_q <= !wrap_dis_i && !cont_d;
        cnt_q  <= '0;
      end
    end else if (stop_i || last_o) begin
      busy_q <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = busy_q;
  assign last_o  = busy_q && (cont_q ? (addr_q == '1) : (cnt_q == mask_q));
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              stop_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o,
  input logic              last_o,
  input logic              wrap_q,
  input logic              cont_q,
  input logic [3:0]        mask_q
);
  logic [ADDR_W-1:0] hi_mask;
  assign hi_mask = ~ADDR_W'(mask_q);

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && start_i |=> valid_o && addr_o == $past(start_addr_i));

  // R7
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R7
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o |=> !valid_o);

  // R9
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && stop_i |=> !valid_o);

  // R3
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !stop_i && !wrap_q |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  // R4
  wrap_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !stop_i && wrap_q |=> (addr_o & hi_mask) == ($past(addr_o) & hi_mask));

  // R6
  cont_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cont_q && addr_o == '1 |-> last_o);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (act_clk),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_addr_i(start_addr_i),
  .stop_i      (stop_i),
  .addr_o      (addr_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .wrap_q      (wrap_q),
  .cont_q      (cont_q),
  .mask_q      (mask_q)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW  = 6;
  localparam int TOP = (1 << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          edge_fall_i = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [2:0]    blen_i = 3'b001;
  logic          wrap_dis_i = 1'b1;
  logic          stop_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o;
  logic          last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_fall_i (edge_fall_i),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .blen_i      (blen_i),
    .wrap_dis_i  (wrap_dis_i),
    .stop_i      (stop_i),
    .addr_o      (addr_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_act();
    if (edge_fall_i) @(negedge clk_i);
    else @(posedge clk_i);
    #1;
  endtask

  // stop_at < 0: no early stop
  task automatic run_burst(input int sa, input int code, input bit wd,
                           input int stop_at, input bit interfere);
    int  len;
    bit  cont;
    int  nb;
    int  n_run;
    int  ea;
    string tag;
    len  = (code == 2) ? 8 : (code == 3) ? 16 : 4;
    cont = (code == 7);
    nb   = cont ? (TOP + 1 - sa) : len;
    n_run = (stop_at >= 0 && stop_at < nb) ? stop_at + 1 : nb;
    tag  = cont ? "R6" : (code == 0 || code > 3) ? "R5" : wd ? "R3" : "R4";
    start_addr_i = AW'(sa);
    blen_i       = 3'(code);
    wrap_dis_i   = wd;
    start_i      = 1'b1;
    wait_act();
    start_i = 1'b0;
    for (int i = 0; i < n_run; i++) begin
      if (cont || wd) ea = (sa + i) & TOP;
      else ea = (sa & ~(len - 1)) | ((sa + i) & (len - 1));
      chk((i == 0) ? "R2 valid" : "R2 valid held", int'(valid_o), 1);
      chk((interfere && i > 0) ? "R8 addr" : tag, int'(addr_o), ea);
      chk("R7 last", int'(last_o), int'(i == nb - 1));
      if (i == 0 && interfere && nb > 2 && stop_at != 0) begin
        start_i      = 1'b1;
        start_addr_i = ~AW'(sa);
        blen_i       = ~3'(code);
        wrap_dis_i   = ~wd;
      end
      if (i == 1) start_i = 1'b0;
      if (i == stop_at) stop_i = 1'b1;
      wait_act();
    end
    start_i = 1'b0;
    stop_i  = 1'b0;
    chk((n_run < nb) ? "R9 idle after stop" : "R7 idle after last", int'(valid_o), 0);
    chk("R7 last idle", int'(last_o), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #7;
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset last", int'(last_o), 0);
    rst_ni = 1'b1;
    wait_act();
    wait_act();
    chk("R1 idle valid", int'(valid_o), 0);

    // exhaustive sweep, rising edge
    for (int code = 0; code < 8; code++)
      for (int wd = 0; wd < 2; wd++)
        for (int sa = 0; sa <= TOP; sa++)
          run_burst(sa, code, wd[0], -1, (sa % 3) == 0);

    // early stop at several beats
    for (int k = 0; k < 4; k++) run_burst(13, 2, 1'b0, k, 1'b0);
    run_burst(2, 7, 1'b0, 5, 1'b1);
    run_burst(9, 3, 1'b1, 10, 1'b1);

    // falling-edge mode
    wait_act();
    edge_fall_i = 1'b1;
    @(negedge clk_i);
    #1;
    start_addr_i = AW'(5);
    blen_i       = 3'b001;
    wrap_dis_i   = 1'b1;
    start_i      = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R10 no start on rising", int'(valid_o), 0);
    @(negedge clk_i);
    #1;
    start_i = 1'b0;
    chk("R10 start on falling", int'(valid_o), 1);
    chk("R10 first addr", int'(addr_o), 5);
    @(posedge clk_i);
    #1;
    chk("R10 hold on rising", int'(addr_o), 5);
    @(negedge clk_i);
    #1;
    chk("R10 advance on falling", int'(addr_o), 6);
    stop_i = 1'b1;
    wait_act();
    stop_i = 1'b0;
    chk("R9 stop falling", int'(valid_o), 0);
    for (int sa = 0; sa < 20; sa++) run_burst(sa * 3, sa % 8, sa[0], -1, sa[1]);
    run_burst(30, 3, 1'b0, -1, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule